// File: doc/BRIEF.md
# Sequential Byte-Sliced Signed Multiplier

This block multiplies two 16-bit two's-complement operands into a 32-bit signed product over several clocks. It has a single unsigned byte-by-byte multiplier. The product is built up in an accumulator that the output port reads directly.

Each operation runs in this order:
- The low-by-low and high-by-high partial products are written into the low and high halves of the accumulator.
- The two cross products are added one after the other at a shift of one byte. Any carry out of the top byte is discarded.
- Up to two sign-correction subtractions are applied to the upper half. The step for the second operand comes before the step for the first operand. A step whose operand is non-negative takes no cycle.

A one-cycle start strobe begins an operation when the block is idle. The busy output covers the run, and a one-clock done pulse marks the moment the product is valid.

Top module: `seq_bytemul`

## Requirements
- R1: After reset, busy and done are 0 and product is 0.
- R2: A start sampled high while busy is 0 is accepted: op_a and op_b are captured and busy is 1 in the following cycle.
- R3: When done is 1, product equals the captured op_a times op_b, both read as signed 16-bit values, reduced to 32 bits.
- R4: done rises exactly 4 + n clock edges after the accepting edge, where n (0..2) is the number of operands whose bit 15 is 1.
- R5: A start sampled while busy is 1 is ignored: the running operation keeps its captured operands and its latency.
- R6: done is high for exactly one cycle, and busy is 0 whenever done is 1.
- R7: While the block is idle and no start is accepted, product keeps its value, including across the cycle after done.
- R8: The product is exact for the corner operands -32768 x -32768, -32768 x 32767, -1 x -1 and 0 x any value, with bits above 32 discarded.
- R9: busy stays 1 without a gap from the accepting edge until the edge that raises done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op_a | input | 16 | First signed operand |
| op_b | input | 16 | Second signed operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when product is valid |
| product | output | 32 | Signed product, held until the next accepted start |

## Verification
The bench builds the block with the default byte width of 8, which gives 16-bit operands and a 32-bit result. This setting reaches the exact extreme operands -32768 and 32767. It also covers all four combinations of operand sign, and so every latency from 4 to 6 cycles. Random operand pairs exercise carries from both cross-product additions and borrows across the upper half during sign correction. Starts issued mid-run test that captured operands survive later changes on the input ports.

// File: rtl/seq_bytemul.sv
module seq_bytemul #(
  parameter int HALF_W = 8,
  localparam int OP_W  = 2 * HALF_W,
  localparam int RES_W = 4 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] product
);

  typedef enum logic [2:0] {
    S_IDLE, S_LL, S_HH, S_XLH, S_XHL, S_FIXB, S_FIXA
  } step_t;

  step_t            step, step_nx;
  logic [OP_W-1:0]  a_q, b_q;
  logic [RES_W-1:0] acc;
  logic [HALF_W-1:0] mx, my;
  logic [OP_W-1:0]  pp;
  logic             a_neg, b_neg;

  assign a_neg   = a_q[OP_W-1];
  assign b_neg   = b_q[OP_W-1];
  assign busy    = (step != S_IDLE);
  assign product = acc;

  always_comb begin
    mx = a_q[HALF_W-1:0];
    my = b_q[HALF_W-1:0];
    case (step)
      S_HH:    begin mx = a_q[OP_W-1:HALF_W]; my = b_q[OP_W-1:HALF_W]; end
      S_XLH:   begin mx = a_q[HALF_W-1:0];    my = b_q[OP_W-1:HALF_W]; end
      S_XHL:   begin mx = a_q[OP_W-1:HALF_W]; my = b_q[HALF_W-1:0];    end
      default: ;
    endcase
  end

  assign pp = mx * my;

  always_comb begin
    step_nx = step;
    case (step)
      S_IDLE:  if (start) step_nx = S_LL;
      S_LL:    step_nx = S_HH;
      S_HH:    step_nx = S_XLH;
      S_XLH:   step_nx = S_XHL;
      S_XHL:   step_nx = b_neg ? S_FIXB : (a_neg ? S_FIXA : S_IDLE);
      S_FIXB:  step_nx = a_neg ? S_FIXA : S_IDLE;
      S_FIXA:  step_nx = S_IDLE;
      default: step_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= S_IDLE;
      a_q  <= '0;
      b_q  <= '0;
      acc  <= '0;
      done <= 1'b0;
    end else begin
      step <= step_nx;
      done <= busy && (step_nx == S_IDLE);
      case (step)
        S_IDLE: if (start) begin a_q <= op_a; b_q <= op_b; end
        S_LL:   acc <= {{OP_W{1'b0}}, pp};
        S_HH:   acc[RES_W-1:OP_W] <= pp;
        S_XLH, S_XHL: acc <= acc + (RES_W'(pp) << HALF_W);
        S_FIXB: acc[RES_W-1:OP_W] <= acc[RES_W-1:OP_W] - a_q;
        S_FIXA: acc[RES_W-1:OP_W] <= acc[RES_W-1:OP_W] - b_q;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/seq_bytemul_chk.sv
module seq_bytemul_chk #(
  parameter int HALF_W = 8,
  localparam int OP_W  = 2 * HALF_W,
  localparam int RES_W = 4 * HALF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [OP_W-1:0]  op_a,
  input logic [OP_W-1:0]  op_b,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] product
);
  logic [OP_W-1:0] a_c, b_c;
  logic [3:0]      lat;
  logic [RES_W-1:0] sa, sb, ref_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_c <= '0; b_c <= '0; lat <= '0;
    end else if (start && !busy) begin
      a_c <= op_a; b_c <= op_b; lat <= 4'd1;
    end else if (busy) begin
      lat <= lat + 4'd1;
    end
  end

  assign sa    = {{OP_W{a_c[OP_W-1]}}, a_c};
  assign sb    = {{OP_W{b_c[OP_W-1]}}, b_c};
  assign ref_p = sa * sb;

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == ref_p));
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == 4'd5 + 4'(a_c[OP_W-1]) + 4'(b_c[OP_W-1])));
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
  assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind seq_bytemul seq_bytemul_chk #(.HALF_W(HALF_W)) u_chk (.*);

// File: tb/sim_seq_bytemul.sv
module sim_seq_bytemul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [31:0] product;
  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  seq_bytemul u0 (.clk, .rst_n, .start, .op_a, .op_b, .busy, .done, .product);

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] x, y;
    x = $signed(a);
    y = $signed(b);
    return 32'(x * y);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit poke, input string req);
    int cyc;
    logic [31:0] exp;
    int exp_lat;
    exp = ref_mul(a, b);
    exp_lat = 4 + int'(a[15]) + int'(b[15]);
    @(negedge clk); op_a = a; op_b = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R2", 32'(busy), 32'd1);
    cyc = 0;
    if (poke) begin
      op_a = ~a; op_b = b ^ 16'h8001; start = 1'b1;
      @(negedge clk); start = 1'b0; cyc++;
    end
    while (!done && cyc < 20) begin
      chk(busy === 1'b1, "R9", 32'(busy), 32'd1);
      @(negedge clk); cyc++;
    end
    chk(cyc == exp_lat, poke ? "R5" : "R4", 32'(cyc), 32'(exp_lat));
    chk(product === exp, req, product, exp);
    chk(busy === 1'b0, "R6", 32'(busy), 32'd0);
    @(negedge clk);
    chk(done === 1'b0, "R6", 32'(done), 32'd0);
    chk(product === exp, "R7", product, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === 32'd0, "R1", product, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && product === 32'd0, "R1", product, 32'd0);

    run_op(16'h8000, 16'h8000, 1'b0, "R8");
    run_op(16'h8000, 16'h7FFF, 1'b0, "R8");
    run_op(16'h7FFF, 16'h8000, 1'b0, "R8");
    run_op(16'hFFFF, 16'hFFFF, 1'b0, "R8");
    run_op(16'h0000, 16'hABCD, 1'b0, "R8");
    run_op(16'h1234, 16'h0000, 1'b0, "R8");
    run_op(16'h00FF, 16'hFF00, 1'b0, "R3");
    run_op(16'h7FFF, 16'h7FFF, 1'b0, "R3");
    run_op(16'hC3A5, 16'h5A3C, 1'b1, "R5");
    run_op(16'h0101, 16'hFEFE, 1'b1, "R5");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      run_op(a, b, ($urandom % 5) == 0, "R3");
      if (($urandom % 3) == 0) begin
        logic [31:0] held;
        held = product;
        repeat (2) @(negedge clk);
        chk(product === held, "R7", product, held);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule